// File: doc/BRIEF.md
# Generation-Bit Event Queue Writer

This block posts interrupt event numbers into a circular queue that lives in ordinary memory and is drained by software. Each notification carries a 31-bit event number. The writer turns it into a 32-bit entry and writes it through a simple word-write port to the next slot of the queue.

There is no shared head pointer and no full or empty flag. Instead, the top bit of every entry is a generation bit. Its sense inverts each time the write index wraps back to slot 0. A consumer keeps its own toggle, starting at 0, and treats any slot whose top bit equals that toggle as empty.

Software sets the queue's base word address and its size (a power of two) through a configuration strobe. Writing the configuration restarts the queue. After reset the queue has its largest size and its base at word 0. Each memory write is held on the port for a fixed number of cycles. One notification that arrives during a write is parked in a skid register, and the writer withdraws its ready until that register empties.

Top module: `evq_writer`

## Requirements
- R1: After reset `mem_we` is 0 and `ev_ready` is 1. The base is word 0 and the queue holds 2^MAX_LOG2 entries.
- R2: An entry word has the generation bit in bit 31 and the event number in bits 30:0. It is driven big-endian on the port: `mem_wdata` = {w[7:0], w[15:8], w[23:16], w[31:24]}. For example, entry 0x80012345 appears as 0x45230180.
- R3: The write address is base + index. The index starts at 0 and advances by one after each write, modulo the number of entries.
- R4: After reset or configuration the generation bit is 1. It inverts every time the index wraps to 0, so a consumer whose toggle starts at 0 reads every entry exactly once, in order.
- R5: Each write keeps `mem_we` high for HOLD_CYCLES consecutive cycles, with address and data stable. It starts in the cycle after the edge that accepts the notification. Writes may follow each other with no gap.
- R6: A notification accepted while a write is in progress is held in a one-entry skid register. `ev_ready` stays 0 while that register is occupied. No accepted event is lost or reordered.
- R7: A cycle with `cfg_we` = 1 loads the new base and size, sets the index to 0 and the generation bit to 1, and ends any write in progress. It also discards any held entry and ignores a notification offered in the same cycle.
- R8: A notification whose event number is 0 is accepted but not written, because a consumer reads 0 as "nothing". The index is left unchanged.
- R9: `cfg_size` gives log2 of the entry count. A value above MAX_LOG2 is treated as MAX_LOG2, and a value of 0 gives a single-entry queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load configuration and restart the queue |
| cfg_base | input | ADDR_W | Queue base word address |
| cfg_size | input | SIZE_W | log2 of the number of entries |
| ev_valid | input | 1 | Event notification present |
| ev_num | input | 31 | Event number |
| ev_ready | output | 1 | Writer can take a notification |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Entry word in big-endian byte order |

## Verification
The hardest state to reach from the ports is a reconfiguration that lands while a write is on the port and the skid register is full. A notification is offered in that same cycle. The stimulus reaches this state by streaming two events back to back and then raising `cfg_where` together with a third valid event, with no idle cycle in between. Generation flips are forced often by using a four-entry queue and a single-entry queue. The clamp is exercised by a full lap of more than 1024 entries. A behavioural consumer with its own toggle drains the memory image and checks that no entry is lost, duplicated or reordered.

// File: rtl/evq_pkg.sv
package evq_pkg;

  typedef struct packed {
    logic        gen;
    logic [30:0] num;
  } evq_entry_t;

  // Reorder bytes so the most significant byte lands at the lowest address.
  function automatic logic [31:0] to_big_endian(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

endpackage

// File: rtl/evq_cfg.sv
module evq_cfg #(
  parameter int ADDR_W   = 30,
  parameter int SIZE_W   = 4,
  parameter int MAX_LOG2 = 10,
  localparam int IDX_W   = MAX_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [SIZE_W-1:0] cfg_size,
  output logic [ADDR_W-1:0] base_q,
  output logic [IDX_W-1:0]  mask_q
);

  localparam logic [SIZE_W-1:0] SIZE_MAX = SIZE_W'(MAX_LOG2);

  function automatic logic [IDX_W-1:0] mask_of(input logic [SIZE_W-1:0] l2);
    logic [IDX_W:0] span;
    span = (IDX_W+1)'(1) << l2;
    return IDX_W'(span - 1'b1);
  endfunction

  logic [SIZE_W-1:0] size_eff;

  // Clamp an oversized request to the largest supported queue (R9)
  always_comb begin
    size_eff = (cfg_size > SIZE_MAX) ? SIZE_MAX : cfg_size;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      mask_q <= mask_of(SIZE_MAX);
    end else if (cfg_we) begin
      base_q <= cfg_base;
      mask_q <= mask_of(size_eff);
    end
  end

endmodule

// File: rtl/evq_index.sv
module evq_index #(
  parameter int MAX_LOG2 = 10,
  localparam int IDX_W   = MAX_LOG2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             advance,
  input  logic [IDX_W-1:0] mask,
  output logic [IDX_W-1:0] idx_q,
  output logic             gen_q
);

  logic [IDX_W-1:0] idx_nxt;

  always_comb begin
    idx_nxt = (idx_q + 1'b1) & mask;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      idx_q <= '0;
      gen_q <= 1'b1;
    end else if (advance) begin
      idx_q <= idx_nxt;
      if (idx_nxt == '0) gen_q <= ~gen_q;
    end
  end

  AST_IDX_IN_MASK: assert property (@(posedge clk) disable iff (rst)
    (idx_q & ~mask) == '0);  // R3

  AST_GEN_FLIPS_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    (advance && !clear && idx_q == mask) |=> (idx_q == '0 && gen_q != $past(gen_q)));  // R4

endmodule

// File: rtl/evq_flow.sv
module evq_flow #(
  parameter int HOLD_CYCLES = 2,
  localparam int CNT_W      = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        ev_valid,
  input  logic [30:0] ev_num,
  output logic        ev_ready,
  output logic        load,
  output logic [30:0] load_num,
  output logic        busy_q
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             skid_full_q;
  logic [30:0]      skid_num_q;
  logic             free;
  logic             take;

  always_comb begin
    free     = !busy_q || (cnt_q == LAST_CNT);
    take     = ev_valid && !skid_full_q && (ev_num != '0) && !clear;
    load     = !clear && free && (skid_full_q || take);
    load_num = skid_full_q ? skid_num_q : ev_num;
    ev_ready = !skid_full_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      busy_q      <= 1'b0;
      cnt_q       <= '0;
      skid_full_q <= 1'b0;
    end else begin
      if (load) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (free) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (free) begin
        skid_full_q <= 1'b0;
      end else if (take) begin
        skid_full_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!free && take) skid_num_q <= ev_num;
  end

  AST_SKID_HELD: assert property (@(posedge clk) disable iff (rst)
    (skid_full_q && !free && !clear) |=> skid_full_q);  // R6

  AST_ZERO_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_num == '0 && !busy_q && !skid_full_q && !clear) |=> !busy_q);  // R8

endmodule

// File: rtl/evq_writer.sv
module evq_writer #(
  parameter int ADDR_W      = 30,
  parameter int SIZE_W      = 4,
  parameter int MAX_LOG2    = 10,
  parameter int HOLD_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic              ev_valid,
  input  logic [30:0]       ev_num,
  output logic              ev_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata
);
  import evq_pkg::*;

  localparam int IDX_W = MAX_LOG2;

  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  mask_q;
  logic [IDX_W-1:0]  idx_q;
  logic              gen_q;
  logic              load;
  logic [30:0]       load_num;
  logic              busy_q;
  evq_entry_t        entry;

  evq_cfg #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MAX_LOG2(MAX_LOG2)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .base_q(base_q), .mask_q(mask_q)
  );

  evq_index #(.MAX_LOG2(MAX_LOG2)) u_index (
    .clk(clk), .rst(rst), .clear(cfg_we), .advance(load),
    .mask(mask_q), .idx_q(idx_q), .gen_q(gen_q)
  );

  evq_flow #(.HOLD_CYCLES(HOLD_CYCLES)) u_flow (
    .clk(clk), .rst(rst), .clear(cfg_we), .ev_valid(ev_valid),
    .ev_num(ev_num), .ev_ready(ev_ready), .load(load),
    .load_num(load_num), .busy_q(busy_q)
  );

  always_comb begin
    entry.gen = gen_q;
    entry.num = load_num;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (load) begin
      mem_addr  <= base_q + ADDR_W'(idx_q);
      mem_wdata <= to_big_endian(entry);
    end
  end

  assign mem_we = busy_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we) && !$past(load) && !$past(cfg_we))
      |-> ($stable(mem_addr) && $stable(mem_wdata)));  // R5

  AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (!mem_we && ev_ready));  // R7

endmodule

// File: tb/test_evq_writer.sv
module test_evq_writer;

  localparam int AW   = 30;
  localparam int SW   = 4;
  localparam int MAXL = 10;
  localparam int HOLD = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [SW-1:0] cfg_size = '0;
  logic          ev_valid = 1'b0;
  logic [30:0]   ev_num = '0;
  logic          ev_ready;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;

  evq_writer #(.ADDR_W(AW), .SIZE_W(SW), .MAX_LOG2(MAXL), .HOLD_CYCLES(HOLD)) i_evq_writer (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .ev_valid(ev_valid), .ev_num(ev_num), .ev_ready(ev_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always #2 clk = ~clk;  // 250 MHz

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // ---------------- reference model (steps on each rising edge) ----------------
  int unsigned pend[$];
  int unsigned explist[$];
  int          left = 0;
  int unsigned m_idx = 0;
  bit          m_gen = 1;
  int unsigned m_base = 0;
  int          m_log2 = MAXL;
  bit [31:0]   m_addr = 0;
  bit [31:0]   m_data = 0;
  bit          m_acc = 0;
  bit          m_restart = 0;
  bit          m_live = 0;

  function automatic bit [31:0] swap_bytes(input bit [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  always @(posedge clk) begin
    m_acc = 0;
    if (rst || cfg_we) begin
      if (rst) begin m_base = 0; m_log2 = MAXL; end
      else begin
        m_base = cfg_base;
        m_log2 = (cfg_size > MAXL) ? MAXL : int'(cfg_size);
      end
      m_idx = 0; m_gen = 1; left = 0;
      pend.delete(); explist.delete();
      m_restart = 1; m_live = 1;
    end else begin
      m_acc = ev_valid && (pend.size() == 0);
      if (left > 0) left--;
      if (m_acc && ev_num != 0) pend.push_back(ev_num);
      if (left == 0 && pend.size() > 0) begin
        int unsigned n;
        n = pend.pop_front();
        m_addr = (m_base + m_idx) & ((1 << AW) - 1);
        m_data = swap_bytes({m_gen, n[30:0]});
        explist.push_back(n);
        m_idx = (m_idx + 1) % (1 << m_log2);
        if (m_idx == 0) m_gen = !m_gen;
        left = HOLD;
      end
    end
  end

  // ---------------- memory image and behavioural consumer ----------------
  bit [31:0]   cmem[int unsigned];
  int unsigned c_idx = 0;
  bit          c_tog = 0;
  int          c_count = 0;
  int          wr_cycles = 0;
  bit          saw_stall = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && m_live && !finished) begin
      if (m_restart) begin
        cmem.delete(); c_idx = 0; c_tog = 0; c_count = 0; m_restart = 0;
      end
      check(mem_we == (left > 0), "R5", "mem_we", mem_we, left > 0);
      check(ev_ready == (pend.size() == 0), "R6", "ev_ready", ev_ready, pend.size() == 0);
      if (!ev_ready) saw_stall = 1;
      if (mem_we) begin
        wr_cycles++;
        check(mem_addr == m_addr[AW-1:0], "R3", "mem_addr", mem_addr, m_addr[AW-1:0]);
        check(mem_wdata == m_data, "R2", "mem_wdata", mem_wdata, m_data);
        cmem[mem_addr] = swap_bytes(mem_wdata);
      end
      // drain every valid entry using the consumer's own toggle
      forever begin
        int unsigned a;
        bit [31:0] w;
        a = (m_base + c_idx) & ((1 << AW) - 1);
        w = cmem.exists(a) ? cmem[a] : 32'h0;
        if (w[31] == c_tog) break;
        if (explist.size() == 0) begin
          check(0, "R4", "unexpected entry", w, 0);
          break;
        end
        check(w[30:0] == explist[0][30:0], "R4", "consumer order", w[30:0], explist[0]);
        void'(explist.pop_front());
        c_count++;
        c_idx = (c_idx + 1) % (1 << m_log2);
        if (c_idx == 0) c_tog = !c_tog;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic put(input int unsigned n);
    ev_valid = 1'b1;
    ev_num   = n[30:0];
    do @(negedge clk); while (!m_acc);
    ev_valid = 1'b0;
  endtask

  task automatic configure(input int unsigned base, input int unsigned l2);
    cfg_we   = 1'b1;
    cfg_base = base[AW-1:0];
    cfg_size = l2[SW-1:0];
    @(negedge clk);
    cfg_we   = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(mem_we == 1'b0 && ev_ready == 1'b1, "R1", "reset outputs",
          {mem_we, ev_ready}, 2'b01);

    // R6, R5: back-to-back stream through the default 1024-entry queue
    wr_cycles = 0;
    for (int i = 1; i <= 20; i++) put(i * 3);
    repeat (8) @(negedge clk);
    check(c_count == 20, "R6", "entries delivered", c_count, 20);
    check(wr_cycles == 20 * HOLD, "R5", "write cycles", wr_cycles, 20 * HOLD);
    check(saw_stall, "R6", "backpressure seen", saw_stall, 1);

    // R2: exact big-endian image of one entry
    configure(32'h80, 4);
    put(32'h12345);
    check(mem_we && mem_wdata == 32'h45230180, "R2", "byte order", mem_wdata, 32'h45230180);
    check(mem_addr == 30'h80, "R3", "first address", mem_addr, 30'h80);
    repeat (4) @(negedge clk);

    // R3, R4: four-entry queue, gaps and bursts, three wraps
    configure(32'h100, 2);
    for (int i = 0; i < 13; i++) begin
      put(100 + i);
      if (i % 3 == 0) repeat (3) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    check(c_idx == 1 && c_tog == 1, "R3", "index/toggle after 13", {c_tog, c_idx[3:0]}, 5'h11);
    check(c_count == 13, "R4", "entries read", c_count, 13);

    // R8: event number zero produces no write
    wr_cycles = 0;
    put(0);
    repeat (4) @(negedge clk);
    check(wr_cycles == 0, "R8", "write after zero event", wr_cycles, 0);
    put(555);
    check(mem_addr == 30'h101, "R8", "index unchanged by zero", mem_addr, 30'h101);
    repeat (4) @(negedge clk);

    // R7: reconfigure with a write in flight, skid full and an event offered
    put(5);
    put(6);
    ev_valid = 1'b1; ev_num = 31'd77;
    configure(32'h300, 3);
    ev_valid = 1'b0;
    check(!mem_we && ev_ready, "R7", "cleared after cfg", {mem_we, ev_ready}, 2'b01);
    put(9);
    check(mem_addr == 30'h300 && mem_wdata == swap_bytes(32'h80000009), "R7",
          "first write after cfg", mem_wdata, swap_bytes(32'h80000009));
    repeat (6) @(negedge clk);
    check(c_count == 1, "R7", "only new entry visible", c_count, 1);

    // R9: single-entry queue, generation flips on every write
    configure(32'h40, 0);
    for (int i = 0; i < 5; i++) begin put(7 + i); repeat (2) @(negedge clk); end
    repeat (4) @(negedge clk);
    check(c_idx == 0 && c_tog == 1 && c_count == 5, "R9", "one-entry queue",
          c_count, 5);

    // R9: oversize request clamps to 1024 entries; includes the reserved marker
    configure(32'h2000, 15);
    for (int i = 1; i <= 1030; i++) put((i == 500) ? (1 << 24) : i);
    repeat (8) @(negedge clk);
    check(c_idx == 6 && c_tog == 1, "R9", "clamped wrap point", c_idx, 6);
    check(c_count == 1030, "R4", "full lap delivered", c_count, 1030);

    finished = 1;
    summary();
  end

endmodule